// File: doc/BRIEF.md
# Interrupt reason register with clock

This block gathers the causes that can pull a processor out of its running program and into its supervisor. Single-cycle event pulses from the rest of the core (typewriter request, lock-in violation, stack over/underflow, end of a supervisor-issued transfer, and an OUT request) set sticky reason bits. A free-running time base advances a counter once per fixed number of microsecond ticks. When the counter wraps it raises a clock-overflow reason, and a second wrap before that reason has been collected raises a fatal double-clock reason.

The block also holds the no-interrupt flip-flop that selects between program and supervisor mode. In program mode any pending reason produces an interrupt request. In supervisor mode reasons are only recorded, except for the double-clock reason. The supervisor collects the reasons through a destructive read: a single strobe returns a 48-bit status word and clears every reason bit that word carried. A return-to-program strobe clears the no-interrupt flip-flop. If any reason is still pending at that point, the block interrupts again at once.

Top module: `irq_reason_unit`

## Requirements
- R1: The time-base counter is zero after reset. It advances by exactly one after every TICKS_PER_COUNT microsecond ticks, wraps from all ones to zero, and is never changed by a status read.
- R2: The clock-overflow reason (status bit 47) is set in the cycle after the tick that wraps the counter.
- R3: A wrap while the clock-overflow reason is already set, with no status read in that cycle, sets the double-clock reason (status bit 18).
- R4: A pulse on the typewriter, lock-in violation, transfer-end or OUT input sets status bit 24, 23, 21 or 20 respectively, in the following cycle.
- R5: A status read clears every reason bit. An event that arrives in the same cycle as the read leaves its bit set.
- R6: When the mode flag is 0 (program), irq_o is high whenever any reason bit is set. When the mode flag is 1 (supervisor), irq_o is low unless the double-clock reason is set.
- R7: A stack over/underflow pulse sets status bit 22 only in program mode. In supervisor mode the pulse is ignored.
- R8: irq_o high at a clock edge sets the mode flag to 1. Only a return-to-program strobe, taken while irq_o is low, clears the flag.
- R9: A return-to-program strobe while a reason is pending clears the mode flag for one cycle. irq_o is high in that cycle, and the flag is set again at the next edge.
- R10: After reset the mode flag is 1, all reason bits are clear and irq_o is low.
- R11: Status bits 46 downward hold the counter without its least significant bit, most significant first, in CNT_W-1 bits. All status bits not named in R2 to R7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle microsecond tick |
| typw_req_i | input | 1 | Typewriter request pulse |
| lockin_viol_i | input | 1 | Lock-in violation pulse |
| stack_err_i | input | 1 | Stack over/underflow pulse |
| xfer_done_i | input | 1 | Supervisor transfer finished pulse |
| out_req_i | input | 1 | OUT request pulse |
| status_rd_i | input | 1 | Destructive status read strobe |
| exit_prog_i | input | 1 | Return-to-program strobe |
| status_o | output | 48 | Reason bits and clock field |
| irq_o | output | 1 | Interrupt request level |
| sup_mode_o | output | 1 | No-interrupt flip-flop (1 = supervisor) |

## Verification
The bench builds the block with TICKS_PER_COUNT=2 and CNT_W=4, so the counter wraps after 32 ticks instead of about a million microseconds. This keeps a first wrap, and a second unread wrap that reaches the double-clock path, within a few hundred cycles. The narrow counter still leaves a three-bit clock field, so the field's alignment and its immunity to reads can be observed. The supervisor-only double-clock interrupt, the read/event collision and the re-interrupt on return are each driven in their own scenario.

// File: rtl/irq_reason_pkg.sv
package irq_reason_pkg;
  localparam int WORD_W  = 48;
  localparam int NUM_RSN = 7;

  typedef enum logic [2:0] {
    RSN_CLK  = 3'd0,
    RSN_TYPW = 3'd1,
    RSN_LIV  = 3'd2,
    RSN_STK  = 3'd3,
    RSN_XFER = 3'd4,
    RSN_OUT  = 3'd5,
    RSN_DBL  = 3'd6
  } rsn_e;

  typedef logic [NUM_RSN-1:0] rsn_vec_t;

  // digit number, counted from the msb of the status word
  function automatic int rsn_digit(int idx);
    case (idx)
      0:       return 0;
      1:       return 23;
      2:       return 24;
      3:       return 25;
      4:       return 26;
      5:       return 27;
      6:       return 29;
      default: return 0;
    endcase
  endfunction

  function automatic int digit_to_bit(int d);
    return WORD_W - 1 - d;
  endfunction
endpackage

// File: rtl/irq_timebase.sv
module irq_timebase #(
  parameter int TICKS_PER_COUNT = 16,
  parameter int CNT_W           = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-2:0] cnt_hi_o,
  output logic             wrap_o
);
  logic             step;
  logic [CNT_W-1:0] cnt_q;

  generate
    if (TICKS_PER_COUNT > 1) begin : g_presc
      localparam int PRE_W = $clog2(TICKS_PER_COUNT);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_COUNT - 1);
      logic [PRE_W-1:0] presc_q;

      assign step = tick_i && (presc_q == PRE_LAST);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      presc_q <= '0;
        else if (step)    presc_q <= '0;
        else if (tick_i)  presc_q <= presc_q + 1'b1;
      end
    end else begin : g_direct
      assign step = tick_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (step) cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o   = step && (&cnt_q);
  assign cnt_hi_o = cnt_q[CNT_W-1:1];

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |=> cnt_q == $past(cnt_q) + 1'b1); // R1
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step |=> $stable(cnt_q)); // R1
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> cnt_q == '0); // R1
endmodule

// File: rtl/irq_reason_bank.sv
module irq_reason_bank
  import irq_reason_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  rsn_vec_t ev_i,
  input  logic     sup_i,
  input  logic     rd_i,
  output rsn_vec_t rsn_o
);
  rsn_vec_t rsn_q;
  rsn_vec_t set;

  for (genvar k = 0; k < NUM_RSN; k++) begin : g_bit
    if (k == int'(RSN_STK)) begin : g_stk
      assign set[k] = ev_i[k] && !sup_i;
    end else if (k == int'(RSN_DBL)) begin : g_dbl
      // second wrap before the first one was collected
      assign set[k] = ev_i[k] || (ev_i[RSN_CLK] && rsn_q[RSN_CLK] && !rd_i);
    end else begin : g_plain
      assign set[k] = ev_i[k];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rsn_q[k] <= 1'b0;
      else         rsn_q[k] <= set[k] || (rsn_q[k] && !rd_i);
    end

    AST_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_i && !ev_i[k] && !(k == int'(RSN_DBL) && ev_i[RSN_CLK]) |=> !rsn_q[k]); // R5
    AST_NO_RD_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsn_q[k] && !rd_i |=> rsn_q[k]); // R5
  end

  assign rsn_o = rsn_q;

  AST_EVT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i[RSN_OUT] && rd_i |=> rsn_q[RSN_OUT]); // R5
  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i[RSN_CLK] |=> rsn_q[RSN_CLK]); // R2
  AST_DBL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i[RSN_CLK] && rsn_q[RSN_CLK] && !rd_i |=> rsn_q[RSN_DBL]); // R3
  AST_STK_SUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sup_i && !rsn_q[RSN_STK] |=> !rsn_q[RSN_STK]); // R7
endmodule

// File: rtl/irq_mode_ctrl.sv
module irq_mode_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_i,
  input  logic fatal_i,
  input  logic exit_i,
  output logic irq_o,
  output logic nif_o
);
  logic nif_q;

  assign irq_o = (pend_i && !nif_q) || fatal_i;

  // entry wins over a simultaneous return
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     nif_q <= 1'b1;
    else if (irq_o)  nif_q <= 1'b1;
    else if (exit_i) nif_q <= 1'b0;
  end

  assign nif_o = nif_q;

  AST_IRQ_ENTERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> nif_q); // R8
  AST_EXIT_LEAVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_i && !irq_o |=> !nif_q); // R8
  AST_NIF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o && !exit_i |=> $stable(nif_q)); // R8
  AST_REENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_i && !irq_o && pend_i |=> irq_o); // R9
endmodule

// File: rtl/irq_reason_unit.sv
module irq_reason_unit
  import irq_reason_pkg::*;
#(
  parameter int TICKS_PER_COUNT = 16,
  parameter int CNT_W           = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              typw_req_i,
  input  logic              lockin_viol_i,
  input  logic              stack_err_i,
  input  logic              xfer_done_i,
  input  logic              out_req_i,
  input  logic              status_rd_i,
  input  logic              exit_prog_i,
  output logic [WORD_W-1:0] status_o,
  output logic              irq_o,
  output logic              sup_mode_o
);
  localparam int FLD_W   = CNT_W - 1;
  localparam int FLD_TOP = WORD_W - 2;

  logic [FLD_W-1:0] cnt_hi;
  logic             wrap;
  rsn_vec_t         ev;
  rsn_vec_t         rsn;
  logic             nif;

  irq_timebase #(
    .TICKS_PER_COUNT(TICKS_PER_COUNT),
    .CNT_W          (CNT_W)
  ) u_tb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .cnt_hi_o(cnt_hi),
    .wrap_o  (wrap)
  );

  always_comb begin
    ev           = '0;
    ev[RSN_CLK]  = wrap;
    ev[RSN_TYPW] = typw_req_i;
    ev[RSN_LIV]  = lockin_viol_i;
    ev[RSN_STK]  = stack_err_i;
    ev[RSN_XFER] = xfer_done_i;
    ev[RSN_OUT]  = out_req_i;
  end

  irq_reason_bank u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ev_i  (ev),
    .sup_i (nif),
    .rd_i  (status_rd_i),
    .rsn_o (rsn)
  );

  irq_mode_ctrl u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (|rsn),
    .fatal_i(rsn[RSN_DBL]),
    .exit_i (exit_prog_i),
    .irq_o  (irq_o),
    .nif_o  (nif)
  );

  always_comb begin
    status_o = '0;
    status_o[FLD_TOP -: FLD_W] = cnt_hi;
    for (int k = 0; k < NUM_RSN; k++) begin
      status_o[digit_to_bit(rsn_digit(k))] = rsn[k];
    end
  end

  assign sup_mode_o = nif;

  AST_DBL_FORCES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[digit_to_bit(29)] |-> irq_o); // R6
  AST_SUP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sup_mode_o && !status_o[digit_to_bit(29)] |-> !irq_o); // R6
  AST_RD_NO_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_rd_i && !tick_i |=> $stable(status_o[FLD_TOP -: FLD_W])); // R1
endmodule

// File: tb/tb_irq_reason_unit.sv
module tb_irq_reason_unit;
  localparam int CLK_P = 10;
  localparam int TPC   = 2;
  localparam int CW    = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, typw = 1'b0, liv = 1'b0, stk = 1'b0;
  logic        xfer = 1'b0, outr = 1'b0, rd = 1'b0, ext = 1'b0;
  logic [47:0] status;
  logic        irq, sup;

  int n_chk = 0;
  int n_bad = 0;
  int ticks = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_reason_unit #(.TICKS_PER_COUNT(TPC), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .typw_req_i(typw),
    .lockin_viol_i(liv), .stack_err_i(stk), .xfer_done_i(xfer),
    .out_req_i(outr), .status_rd_i(rd), .exit_prog_i(ext),
    .status_o(status), .irq_o(irq), .sup_mode_o(sup)
  );

  task automatic chk(string tag, logic [47:0] got, logic [47:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  function automatic logic [2:0] exp_fld();
    int c = (ticks / TPC) % (1 << CW);
    return 3'(c >> 1);
  endfunction

  task automatic do_read();
    rd = 1'b1; cyc(); rd = 1'b0;
  endtask

  task automatic do_ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; cyc(); ticks++;
    end
    tick = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 status", status, 48'h0);
    chk("R10 mode", 48'(sup), 48'h1);
    chk("R10 irq", 48'(irq), 48'h0);
  endtask

  task automatic t_events_sup();
    typw = 1'b1; cyc(); typw = 1'b0;
    chk("R4 typewriter bit24", status, 48'h1 << 24);
    liv = 1'b1; xfer = 1'b1; outr = 1'b1; cyc();
    liv = 1'b0; xfer = 1'b0; outr = 1'b0;
    chk("R4 liv/xfer/out", status, (48'h1 << 24) | (48'h1 << 23) | (48'h1 << 21) | (48'h1 << 20));
    stk = 1'b1; cyc(); stk = 1'b0;
    chk("R7 stack ignored in supervisor", 48'(status[22]), 48'h0);
    chk("R6 no irq in supervisor", 48'(irq), 48'h0);
    rd = 1'b1;
    #1 chk("R5 read returns reasons", status, (48'h1 << 24) | (48'h1 << 23) | (48'h1 << 21) | (48'h1 << 20));
    cyc(); rd = 1'b0;
    chk("R5 read clears all", status, 48'h0);
  endtask

  task automatic t_collision();
    typw = 1'b1; cyc(); typw = 1'b0;
    rd = 1'b1; typw = 1'b1; outr = 1'b1; cyc();
    rd = 1'b0; typw = 1'b0; outr = 1'b0;
    chk("R5 event during read kept", status, (48'h1 << 24) | (48'h1 << 20));
    do_read();
    chk("R5 second read clears", status, 48'h0);
  endtask

  task automatic t_counter();
    do_ticks(1);
    chk("R1 no step before TPC ticks", 48'(status[46:44]), 48'(exp_fld()));
    do_ticks(3);
    chk("R11 field after 2 counts", status, 48'(exp_fld()) << 44);
    chk("R1 field value", 48'(status[46:44]), 48'h1);
    cyc(); cyc();
    chk("R1 counter holds without ticks", 48'(status[46:44]), 48'h1);
    do_read();
    chk("R1 read leaves counter", 48'(status[46:44]), 48'h1);
  endtask

  task automatic t_wrap();
    do_ticks(32 - ticks - 1);
    chk("R2 no overflow before wrap", 48'(status[47]), 48'h0);
    do_ticks(1);
    chk("R2 overflow on wrap", status, 48'h1 << 47);
    chk("R6 overflow no irq in supervisor", 48'(irq), 48'h0);
    do_ticks(32);
    chk("R3 double-clock set", status, (48'h1 << 47) | (48'h1 << 18));
    chk("R6 double-clock interrupts supervisor", 48'(irq), 48'h1);
    chk("R8 mode stays supervisor", 48'(sup), 48'h1);
    do_read();
    chk("R5 read clears clock reasons", status, 48'h0);
    chk("R6 irq drops after read", 48'(irq), 48'h0);
  endtask

  task automatic t_program();
    ext = 1'b1; cyc(); ext = 1'b0;
    chk("R8 exit clears mode", 48'(sup), 48'h0);
    chk("R6 idle program no irq", 48'(irq), 48'h0);
    stk = 1'b1; cyc(); stk = 1'b0;
    chk("R7 stack bit22 in program", status, 48'h1 << 22);
    chk("R6 irq in program", 48'(irq), 48'h1);
    chk("R8 mode still program", 48'(sup), 48'h0);
    cyc();
    chk("R8 irq enters supervisor", 48'(sup), 48'h1);
    chk("R6 irq low once supervisor", 48'(irq), 48'h0);
    do_read();
    chk("R5 stack reason cleared", status, 48'h0);
  endtask

  task automatic t_reenter();
    liv = 1'b1; cyc(); liv = 1'b0;
    ext = 1'b1; cyc(); ext = 1'b0;
    chk("R9 exit with pending clears mode", 48'(sup), 48'h0);
    chk("R9 immediate irq", 48'(irq), 48'h1);
    cyc();
    chk("R9 back in supervisor", 48'(sup), 48'h1);
    chk("R9 reason still held", status, 48'h1 << 23);
    do_read();
    chk("R5 final clear", status, 48'h0);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_P * 20000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_events_sup();
    t_collision();
    t_counter();
    t_wrap();
    t_program();
    t_reenter();
    summary();
    $finish;
  end
endmodule